// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single transfer requests into bus cycles on a bus whose low lines carry the address first and the data afterwards. A requester hands over one request at a time through a valid/ready pair. The request names the kind of cycle, the address, which byte lanes take part and, for a write, the data. The sequencer then moves through the phases T1, T2, T3, any number of wait phases TW, and T4. In each phase it drives the address strobe, the read, write and interrupt-acknowledge strobes, the memory/IO select, the transceiver direction and enable, and the upper-byte enable. Read data and interrupt vectors come back on a response channel.

Request kinds use these `req_kind` codes: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 interrupt acknowledge. Codes 5 to 7 are reserved and run as I/O reads. `req_lanes` bit 1 requests the upper byte lane and bit 0 requests the lower byte lane.

Back-pressure works in two places. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The response is held with `rsp_data` stable until `rsp_ready` is seen high. No new request is taken while a response is still waiting. While `yield_bus` is high, the bus belongs to another master: no cycle starts and the shared lines are not driven.

Top module: `mux_bus_seq`

## Requirements
- R1: `req_ready` is high only when the sequencer is idle, no response is pending and `yield_bus` is low. An accepted request makes the next clock phase T1. After reset the sequencer is idle with every strobe inactive.
- R2: `ale` is high in T1 and in no other phase.
- R3: In T1 of every cycle except interrupt acknowledge, `ad_oe` is high and `ad_out` carries address bits DATA_W-1..1 with bit 0 equal to the inverted lower-lane request. `a_hi` carries the upper address bits of the latest accepted request (0 after reset).
- R4: The phases T2, T3 and TW are the strobe phases. In these phases `rd_n` is low for read kinds, `wr_n` is low for write kinds and `inta_n` is low for interrupt acknowledge. At most one of the four strobes (`ale`, `rd_n`, `wr_n`, `inta_n`) is active at a time.
- R5: When `bus_ready` is low at the end of T3 or TW, the next phase is TW. When it is high, the next phase is T4. T4 is always followed by at least one idle clock.
- R6: `m_io` is high for kinds 0 and 1 and low for every other kind. It keeps its value between cycles and is 0 after reset.
- R7: `bhe_n` equals the inverse of `req_lanes[1]` and address bit 0 equals the inverse of `req_lanes[0]`. This gives: lanes 11 is a whole word at an even address (0,0); lanes 10 is the upper byte at an odd address (0,1); lanes 01 is the lower byte at an even address (1,0); lanes 00 is no byte (1,1). `bhe_n` is 1 after reset.
- R8: `dt_r` is high for write kinds and low otherwise. `den_n` is low in the strobe phases, and also in T4 of a write cycle.
- R9: In a write cycle, `ad_oe` is high and `ad_out` equals the write data from T2 through T4.
- R10: During an interrupt-acknowledge cycle, `ad_oe` stays low in every phase.
- R11: For read kinds and interrupt acknowledge, `ad_in` is captured on the edge that leaves T3 or TW with `bus_ready` high. `rsp_valid` rises with that capture and holds, with `rsp_data` unchanged, until an edge with `rsp_ready` high.
- R12: While `yield_bus` is high and the sequencer is idle, `req_ready` and `ad_oe` are low and no cycle begins, even with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | ADDR_W | Byte address |
| req_lanes | input | 2 | Lane request, bit 1 upper, bit 0 lower |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data or vector waiting |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | DATA_W | Captured read data |
| yield_bus | input | 1 | Bus granted to another master |
| bus_ready | input | 1 | Transfer completion from the device |
| ad_in | input | DATA_W | Shared lines as seen from the bus |
| ad_out | output | DATA_W | Value driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| a_hi | output | ADDR_W-DATA_W | Upper address lines |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| m_io | output | 1 | High for memory, low for I/O |
| dt_r | output | 1 | Transceiver direction, high transmit |
| den_n | output | 1 | Transceiver enable, active low |
| bhe_n | output | 1 | Upper byte enable, active low |

## Verification
Two things can happen on one clock edge: a response is captured at the end of a wait phase, and `rsp_ready` is held low. The capture sets `rsp_valid`, and the held response must block the next request even though the bus has already gone back to idle. The bench also sets up a second collision: `yield_bus` rises while a request is already offered, so a grant to another master and a pending start meet in the same idle cycle. Both cases are judged every clock against a behavioural model of phases, latched request fields and the response slot. That model predicts each strobe, drive enable and handshake output.

// File: rtl/mux_bus_seq_pkg.sv
package mux_bus_seq_pkg;

  typedef enum logic [2:0] {
    BK_MEM_RD = 3'd0,
    BK_MEM_WR = 3'd1,
    BK_IO_RD  = 3'd2,
    BK_IO_WR  = 3'd3,
    BK_INTA   = 3'd4
  } bus_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  function automatic logic kind_is_write(input logic [2:0] k);
    return (k == BK_MEM_WR) || (k == BK_IO_WR);
  endfunction

  function automatic logic kind_is_mem(input logic [2:0] k);
    return (k == BK_MEM_RD) || (k == BK_MEM_WR);
  endfunction

  function automatic logic kind_is_inta(input logic [2:0] k);
    return k == BK_INTA;
  endfunction

endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import mux_bus_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   bus_ready,
  output phase_e phase,
  output logic   capture
);

  phase_e phase_d;

  assign capture = ((phase == PH_T3) || (phase == PH_TW)) && bus_ready;

  always_comb begin
    phase_d = phase;
    case (phase)
      PH_IDLE: if (start) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3,
      PH_TW:   phase_d = bus_ready ? PH_T4 : PH_TW;
      PH_T4:   phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_T3) || (phase == PH_TW)) && !bus_ready |=> phase == PH_TW);

  // R5
  t4_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_T4 |=> phase == PH_IDLE);

  // R1
  start_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> phase == PH_T1);

endmodule

// File: rtl/bus_seq_req.sv
module bus_seq_req
  import mux_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              capture,
  input  logic [2:0]        in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_lanes,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] ad_in,
  input  logic              rsp_ready,
  output logic [2:0]        kind,
  output logic [DATA_W-1:0] addr_lo,
  output logic [HI_W-1:0]   a_hi,
  output logic              lower_n,
  output logic [DATA_W-1:0] wdata,
  output logic              m_io,
  output logic              dt_r,
  output logic              bhe_n,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind    <= BK_IO_RD;
      addr_lo <= '0;
      a_hi    <= '0;
      lower_n <= 1'b1;
      wdata   <= '0;
      m_io    <= 1'b0;
      dt_r    <= 1'b0;
      bhe_n   <= 1'b1;
    end else if (start) begin
      kind    <= in_kind;
      addr_lo <= in_addr[DATA_W-1:0];
      a_hi    <= in_addr[ADDR_W-1:DATA_W];
      lower_n <= ~in_lanes[0];
      wdata   <= in_wdata;
      m_io    <= kind_is_mem(in_kind);
      dt_r    <= kind_is_write(in_kind);
      bhe_n   <= ~in_lanes[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (capture && !kind_is_write(kind)) begin
      rsp_valid <= 1'b1;
      rsp_data  <= ad_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
  import mux_bus_seq_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [2:0]        kind,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic              lower_n,
  input  logic [DATA_W-1:0] wdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inta_n,
  output logic              den_n,
  output logic              ad_oe,
  output logic [DATA_W-1:0] ad_out
);

  logic strobe_ph, is_wr, is_ia;

  assign strobe_ph = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
  assign is_wr     = kind_is_write(kind);
  assign is_ia     = kind_is_inta(kind);

  assign ale    = (phase == PH_T1);
  assign rd_n   = !(strobe_ph && !is_wr && !is_ia);
  assign wr_n   = !(strobe_ph && is_wr);
  assign inta_n = !(strobe_ph && is_ia);
  assign den_n  = !(strobe_ph || (phase == PH_T4 && is_wr));
  assign ad_oe  = !is_ia &&
                  ((phase == PH_T1) || (is_wr && (strobe_ph || phase == PH_T4)));
  assign ad_out = (phase == PH_T1) ? {addr_lo[DATA_W-1:1], lower_n} : wdata;

  // R2
  ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!rd_n, !wr_n, !inta_n, ale}) <= 1);

  // R10
  inta_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n |-> !ad_oe);

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_lanes,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              yield_bus,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   a_hi,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inta_n,
  output logic              m_io,
  output logic              dt_r,
  output logic              den_n,
  output logic              bhe_n
);

  phase_e            phase;
  logic              capture, start, lower_n;
  logic [2:0]        kind;
  logic [DATA_W-1:0] addr_lo, wdata;

  assign req_ready = (phase == PH_IDLE) && !rsp_valid && !yield_bus;
  assign start     = req_valid && req_ready;

  bus_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_ready(bus_ready),
    .phase(phase), .capture(capture)
  );

  bus_seq_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_n), .start(start), .capture(capture),
    .in_kind(req_kind), .in_addr(req_addr), .in_lanes(req_lanes),
    .in_wdata(req_wdata), .ad_in(ad_in), .rsp_ready(rsp_ready),
    .kind(kind), .addr_lo(addr_lo), .a_hi(a_hi), .lower_n(lower_n),
    .wdata(wdata), .m_io(m_io), .dt_r(dt_r), .bhe_n(bhe_n),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  bus_seq_drive #(.DATA_W(DATA_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .phase(phase), .kind(kind),
    .addr_lo(addr_lo), .lower_n(lower_n), .wdata(wdata),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n),
    .den_n(den_n), .ad_oe(ad_oe), .ad_out(ad_out)
  );

  // R12
  yield_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yield_bus |-> !req_ready);

endmodule

// File: tb/tb_mux_bus_seq.sv
module tb_mux_bus_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1, yield_bus = 1'b0, bus_ready = 1'b1;
  logic [2:0] req_kind = 3'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_lanes = 2'b11;
  logic [DATA_W-1:0] req_wdata = '0, ad_in = '0;
  logic req_ready, rsp_valid, ad_oe, ale, rd_n, wr_n, inta_n, m_io, dt_r, den_n, bhe_n;
  logic [DATA_W-1:0] rsp_data, ad_out;
  logic [ADDR_W-DATA_W-1:0] a_hi;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  mux_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_lanes(req_lanes),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .yield_bus(yield_bus), .bus_ready(bus_ready),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .m_io(m_io), .dt_r(dt_r),
    .den_n(den_n), .bhe_n(bhe_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string sig, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, sig, act, exp, cyc);
    end
  endtask

  // behavioural reference: ph 0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4
  int ph = 0;
  logic [2:0] m_kind = 3'd2;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [1:0] m_lanes = 2'b11;
  logic [DATA_W-1:0] m_wdata = '0, m_rsp = '0;
  logic m_rspv = 0, m_mem = 0, m_wr = 0, m_bhe = 1;

  always @(negedge clk) ad_in <= 16'hA5C3 ^ DATA_W'(cyc * 16'h0137);

  always @(posedge clk) begin
    int nph;
    logic isw, ria;
    cyc++;
    if (!rst_n) begin
      ph = 0; m_rspv = 0; m_rsp = '0; m_mem = 0; m_wr = 0; m_bhe = 1;
      m_kind = 3'd2; m_addr = '0; m_lanes = 2'b11; m_wdata = '0;
    end else begin
      isw = (m_kind == 3'd1) || (m_kind == 3'd3);
      nph = ph;
      if (m_rspv && rsp_ready) m_rspv = 0;
      case (ph)
        0: if (req_valid && !yield_bus && !m_rspv_prev()) begin
             m_kind = req_kind; m_addr = req_addr; m_lanes = req_lanes;
             m_wdata = req_wdata; m_mem = (req_kind <= 3'd1);
             m_wr = (req_kind == 3'd1) || (req_kind == 3'd3);
             m_bhe = ~req_lanes[1]; nph = 1;
           end
        1: nph = 2;
        2: nph = 3;
        3, 4: if (bus_ready) begin
                nph = 5;
                if (!isw) begin m_rspv = 1; m_rsp = ad_in; end
              end else nph = 4;
        default: nph = 0;
      endcase
      ph = nph;
    end
    #(CLK_PERIOD/4);
    if (rst_n) begin
      logic act, w, ia, rd;
      logic [DATA_W-1:0] aexp;
      act = (ph >= 2) && (ph <= 4);
      w = (m_kind == 3'd1) || (m_kind == 3'd3);
      ia = (m_kind == 3'd4);
      rd = !w && !ia;
      chk("R1", "req_ready", req_ready, (ph == 0) && !m_rspv && !yield_bus);
      chk("R2", "ale", ale, ph == 1);
      chk("R4", "rd_n", rd_n, !(act && rd));
      chk("R4", "wr_n", wr_n, !(act && w));
      chk("R4", "inta_n", inta_n, !(act && ia));
      chk("R6", "m_io", m_io, m_mem);
      chk("R7", "bhe_n", bhe_n, m_bhe);
      chk("R8", "dt_r", dt_r, m_wr);
      chk("R8", "den_n", den_n, !(act || (ph == 5 && w)));
      chk("R3", "a_hi", a_hi, m_addr[ADDR_W-1:DATA_W]);
      if (ph == 0) chk("R12", "ad_oe_idle", ad_oe, 0);
      else if (ia) chk("R10", "ad_oe_inta", ad_oe, 0);
      else if (ph == 1) begin
        aexp = {m_addr[DATA_W-1:1], ~m_lanes[0]};
        chk("R3", "ad_oe_t1", ad_oe, 1);
        chk("R7", "ad_out_t1", ad_out, aexp);
      end else if (w) begin
        chk("R9", "ad_oe_wr", ad_oe, 1);
        chk("R9", "ad_out_wr", ad_out, m_wdata);
      end else chk("R4", "ad_oe_rd", ad_oe, 0);
      chk("R11", "rsp_valid", rsp_valid, m_rspv);
      if (m_rspv) chk("R11", "rsp_data", rsp_data, m_rsp);
      if (yield_bus && ph == 0) chk("R12", "no_start", ale, 0);
    end
  end

  // response-slot state before this edge's consumption, kept for acceptance
  logic rspv_q = 0;
  always @(negedge clk) rspv_q <= m_rspv;
  function automatic logic m_rspv_prev();
    return rspv_q;
  endfunction

  task automatic run(input logic [2:0] k, input logic [ADDR_W-1:0] a, input logic [1:0] l,
                     input logic [DATA_W-1:0] d, input int nwait, input int ycyc);
    if (ycyc > 0) yield_bus = 1'b1;
    req_kind = k; req_addr = a; req_lanes = l; req_wdata = d; req_valid = 1'b1;
    repeat (ycyc) @(negedge clk);
    yield_bus = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    if (nwait > 0) begin
      bus_ready = 1'b0;
      repeat (nwait + 1) @(negedge clk);
      bus_ready = 1'b1;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset_ale", ale, 0);
    chk("R1", "reset_strobes", {rd_n, wr_n, inta_n}, 3'b111);
    chk("R1", "reset_oe", ad_oe, 0);
    chk("R7", "reset_bhe", bhe_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    run(3'd0, 20'h52344, 2'b11, 16'h0000, 0, 0);   // mem read word, R5 no wait
    run(3'd1, 20'h30101, 2'b10, 16'hBEEF, 2, 0);   // mem write upper, R9 with waits
    rsp_ready = 1'b0;                              // R11 held response
    run(3'd2, 20'h00402, 2'b01, 16'h0000, 1, 0);
    repeat (3) @(negedge clk);
    rsp_ready = 1'b1;
    run(3'd3, 20'hF0077, 2'b00, 16'h1234, 3, 0);   // io write no lanes
    run(3'd4, 20'h00000, 2'b11, 16'h0000, 1, 0);   // R10 inta
    run(3'd0, 20'hA8F01, 2'b10, 16'h0000, 0, 5);   // R12 yield with request offered
    run(3'd1, 20'h1FFFE, 2'b11, 16'h55AA, 0, 0);
    run(3'd2, 20'h00001, 2'b10, 16'h0000, 4, 0);
    run(3'd4, 20'h00000, 2'b11, 16'h0000, 0, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule